// File: doc/BRIEF.md
# Tag-Snooping Operand Wait Pool

This block is a small pool of waiting slots placed in front of one execution unit of an out-of-order core. An instruction enters a free slot together with its operation code, the reorder-buffer index reserved for its result and two source operands. Each source either arrives as a value or arrives as the reorder-buffer index of the older instruction that will produce it. In the second case the slot keeps the index and watches the result broadcast bus. When a broadcast with that index appears, the slot latches the value.

A slot whose two sources both hold values may be offered to the execution unit. If several slots are ready, the one allocated earliest is offered first, and at most one is handed over per cycle. The reorder-buffer index of the result travels with the operation. After hand-over the slot stays occupied until the result broadcast carries its own result index; the slot is then released. A flush input empties the whole pool in one cycle when speculation is abandoned.

Top module: `rs_tag_pool`

## Requirements
- R1: `iss_accept_o` is 1 exactly when `iss_valid_i` is 1, `iss_rob_room_i` is 1, `flush_i` is 0 and at least one slot is free. `pool_full_o` is 1 when all NUM_ENT slots are occupied. A request that is not accepted leaves the pool unchanged.
- R2: At acceptance, a source whose ok flag (`iss_a_ok_i` / `iss_b_ok_i`) is 1 is stored as the given value. A source whose ok flag is 0 stores the given tag and waits.
- R3: A dispatched operation presents the operation code, both source values and the result index that were supplied when it was accepted.
- R4: A waiting source latches `cdb_val_i` on a clock edge where `cdb_valid_i` is 1 and `cdb_tag_i` equals its stored tag. A broadcast with any other tag leaves it waiting.
- R5: A broadcast that matches a source tag in the same cycle that the source is accepted is captured, and that source is treated as holding the value.
- R6: `dsp_valid_o` is 1 only while some occupied, not-yet-dispatched slot holds values for both sources. A slot is handed over on an edge where `dsp_valid_o` and `dsp_ready_i` are both 1, and it is never offered again.
- R7: Among ready slots, the one accepted earliest is offered first, whatever its slot position.
- R8: A handed-over slot becomes free on the edge where a broadcast carries its result index, and it can be allocated again from the next cycle.
- R9: `flush_i` frees every slot on the next edge. In the flush cycle `iss_accept_o` and `dsp_valid_o` are 0. A flushed slot never dispatches, even if its awaited tag is broadcast later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Discard every slot |
| iss_valid_i | input | 1 | Instruction offered for acceptance |
| iss_rob_room_i | input | 1 | Reorder buffer has a free slot for it |
| iss_op_i | input | OP_W | Operation code |
| iss_dst_i | input | TAG_W | Reorder-buffer index of the result |
| iss_a_ok_i | input | 1 | Source A supplied as a value |
| iss_a_val_i | input | DATA_W | Source A value |
| iss_a_tag_i | input | TAG_W | Source A producer index |
| iss_b_ok_i | input | 1 | Source B supplied as a value |
| iss_b_val_i | input | DATA_W | Source B value |
| iss_b_tag_i | input | TAG_W | Source B producer index |
| iss_accept_o | output | 1 | Instruction taken this cycle |
| pool_full_o | output | 1 | No free slot |
| cdb_valid_i | input | 1 | Result broadcast valid |
| cdb_tag_i | input | TAG_W | Broadcast result index |
| cdb_val_i | input | DATA_W | Broadcast result value |
| dsp_valid_o | output | 1 | Ready operation offered |
| dsp_ready_i | input | 1 | Execution unit takes the offer |
| dsp_op_o | output | OP_W | Offered operation code |
| dsp_a_o | output | DATA_W | Offered source A |
| dsp_b_o | output | DATA_W | Offered source B |
| dsp_dst_o | output | TAG_W | Offered result index |

## Verification
Two sets of events can fall on the same edge. First, a broadcast can resolve a tag while that very source is being accepted. Second, a flush can arrive together with an issue request while a ready slot is being offered. The bench drives the broadcast with the matching tag in the acceptance cycle and expects that slot to be offered with the broadcast value on the following cycle. It raises flush together with an issue request and a live offer, expects both `iss_accept_o` and `dsp_valid_o` low in that cycle, and then broadcasts the tag a flushed slot was waiting on to confirm that nothing is offered afterwards.

// File: rtl/rs_tag_pkg.sv
package rs_tag_pkg;
   // lifecycle of one waiting slot
   typedef enum logic [1:0] {
      ST_FREE = 2'd0,   // available for allocation
      ST_WAIT = 2'd1,   // holds an instruction not yet handed over
      ST_SENT = 2'd2    // handed over, waiting for its own result broadcast
   } rs_state_e;

   localparam int unsigned RS_NUM_SRC = 2;
endpackage

// File: rtl/rs_opnd.sv
module rs_opnd #(
   parameter int unsigned TAG_W  = 3,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic              live,
   input  logic              in_ok,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [DATA_W-1:0] in_val,
   input  logic              cdb_valid,
   input  logic [TAG_W-1:0]  cdb_tag,
   input  logic [DATA_W-1:0] cdb_val,
   output logic              ok,
   output logic [DATA_W-1:0] val
);
   logic              ok_q;
   logic [TAG_W-1:0]  tag_q;
   logic [DATA_W-1:0] val_q;
   logic              hit_new;
   logic              hit_old;

   assign hit_new = cdb_valid && (cdb_tag == in_tag);
   assign hit_old = cdb_valid && (cdb_tag == tag_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ok_q  <= 1'b0;
         tag_q <= '0;
         val_q <= '0;
      end else if (alloc) begin
         tag_q <= in_tag;
         if (in_ok) begin
            ok_q  <= 1'b1;
            val_q <= in_val;
         end else if (hit_new) begin
            ok_q  <= 1'b1;
            val_q <= cdb_val;
         end else begin
            ok_q  <= 1'b0;
         end
      end else if (live && !ok_q && hit_old) begin
         ok_q  <= 1'b1;
         val_q <= cdb_val;
      end
   end

   assign ok  = ok_q;
   assign val = val_q;

   AST_SNOOP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !alloc && !ok_q && cdb_valid && cdb_tag == tag_q)
      |=> (ok_q && val_q == $past(cdb_val))); // R4
   AST_ISSUE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc && !in_ok && cdb_valid && cdb_tag == in_tag)
      |=> (ok_q && val_q == $past(cdb_val))); // R5
   AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !alloc && !ok_q && !(cdb_valid && cdb_tag == tag_q))
      |=> !ok_q); // R4
endmodule

// File: rtl/rs_entry.sv
module rs_entry
   import rs_tag_pkg::*;
#(
   parameter int unsigned TAG_W  = 3,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned OP_W   = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               flush,
   input  logic                               alloc,
   input  logic                               take,
   input  logic [OP_W-1:0]                    in_op,
   input  logic [TAG_W-1:0]                   in_dst,
   input  logic [RS_NUM_SRC-1:0]              in_ok,
   input  logic [RS_NUM_SRC-1:0][TAG_W-1:0]   in_tag,
   input  logic [RS_NUM_SRC-1:0][DATA_W-1:0]  in_val,
   input  logic                               cdb_valid,
   input  logic [TAG_W-1:0]                   cdb_tag,
   input  logic [DATA_W-1:0]                  cdb_val,
   output logic                               busy,
   output logic                               req,
   output logic [OP_W-1:0]                    op,
   output logic [TAG_W-1:0]                   dst,
   output logic [RS_NUM_SRC-1:0][DATA_W-1:0]  src_val
);
   rs_state_e          state_q;
   logic [OP_W-1:0]    op_q;
   logic [TAG_W-1:0]   dst_q;
   logic [RS_NUM_SRC-1:0] src_ok;
   logic               live;
   logic               own_result;

   assign live       = (state_q != ST_FREE);
   assign own_result = cdb_valid && (cdb_tag == dst_q);

   for (genvar s = 0; s < RS_NUM_SRC; s++) begin : g_src
      rs_opnd #(.TAG_W(TAG_W), .DATA_W(DATA_W)) i_opnd (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc     (alloc),
         .live      (live),
         .in_ok     (in_ok[s]),
         .in_tag    (in_tag[s]),
         .in_val    (in_val[s]),
         .cdb_valid (cdb_valid),
         .cdb_tag   (cdb_tag),
         .cdb_val   (cdb_val),
         .ok        (src_ok[s]),
         .val       (src_val[s])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_FREE;
         op_q    <= '0;
         dst_q   <= '0;
      end else if (flush) begin
         state_q <= ST_FREE;
      end else begin
         unique case (state_q)
            ST_FREE: if (alloc) begin
               state_q <= ST_WAIT;
               op_q    <= in_op;
               dst_q   <= in_dst;
            end
            ST_WAIT: if (take) state_q <= ST_SENT;
            ST_SENT: if (own_result) state_q <= ST_FREE;
            default: state_q <= ST_FREE;
         endcase
      end
   end

   assign busy = live;
   assign req  = (state_q == ST_WAIT) && (&src_ok);
   assign op   = op_q;
   assign dst  = dst_q;

   AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> (state_q == ST_FREE)); // R1
   AST_TAKE_NEEDS_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> ((state_q == ST_WAIT) && (&src_ok))); // R6
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (state_q == ST_FREE)); // R9
   AST_RELEASE_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SENT && own_result) |=> (state_q == ST_FREE)); // R8
endmodule

// File: rtl/rs_age.sv
module rs_age #(
   parameter int unsigned NUM_ENT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_ENT-1:0] alloc,
   input  logic [NUM_ENT-1:0] req,
   output logic [NUM_ENT-1:0] sel
);
   // before_q[i][j] set: slot i was allocated before slot j
   logic [NUM_ENT-1:0][NUM_ENT-1:0] before_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         before_q <= '0;
      end else begin
         for (int k = 0; k < NUM_ENT; k++) begin
            if (alloc[k]) begin
               for (int j = 0; j < NUM_ENT; j++) begin
                  if (j != k) begin
                     before_q[k][j] <= 1'b0;
                     before_q[j][k] <= 1'b1;
                  end
               end
            end
         end
      end
   end

   always_comb begin
      for (int i = 0; i < NUM_ENT; i++) begin
         logic blocked;
         blocked = 1'b0;
         for (int j = 0; j < NUM_ENT; j++) begin
            if (j != i && req[j] && before_q[j][i]) blocked = 1'b1;
         end
         sel[i] = req[i] && !blocked;
      end
   end

   AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel)); // R7
   AST_PICK_WHEN_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> (|sel)); // R7
endmodule

// File: rtl/rs_pick_free.sv
module rs_pick_free #(
   parameter int unsigned NUM_ENT   = 4,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic [NUM_ENT-1:0] free,
   output logic [NUM_ENT-1:0] pick,
   output logic               any
);
   if (LOW_FIRST) begin : g_low
      always_comb begin
         logic found;
         found = 1'b0;
         pick  = '0;
         for (int i = 0; i < NUM_ENT; i++) begin
            if (free[i] && !found) begin
               pick[i] = 1'b1;
               found   = 1'b1;
            end
         end
      end
   end else begin : g_high
      always_comb begin
         logic found;
         found = 1'b0;
         pick  = '0;
         for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (free[i] && !found) begin
               pick[i] = 1'b1;
               found   = 1'b1;
            end
         end
      end
   end

   assign any = |free;
endmodule

// File: rtl/rs_tag_pool.sv
module rs_tag_pool
   import rs_tag_pkg::*;
#(
   parameter int unsigned NUM_ENT   = 4,
   parameter int unsigned TAG_W     = 3,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned OP_W      = 4,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              iss_valid_i,
   input  logic              iss_rob_room_i,
   input  logic [OP_W-1:0]   iss_op_i,
   input  logic [TAG_W-1:0]  iss_dst_i,
   input  logic              iss_a_ok_i,
   input  logic [DATA_W-1:0] iss_a_val_i,
   input  logic [TAG_W-1:0]  iss_a_tag_i,
   input  logic              iss_b_ok_i,
   input  logic [DATA_W-1:0] iss_b_val_i,
   input  logic [TAG_W-1:0]  iss_b_tag_i,
   output logic              iss_accept_o,
   output logic              pool_full_o,
   input  logic              cdb_valid_i,
   input  logic [TAG_W-1:0]  cdb_tag_i,
   input  logic [DATA_W-1:0] cdb_val_i,
   output logic              dsp_valid_o,
   input  logic              dsp_ready_i,
   output logic [OP_W-1:0]   dsp_op_o,
   output logic [DATA_W-1:0] dsp_a_o,
   output logic [DATA_W-1:0] dsp_b_o,
   output logic [TAG_W-1:0]  dsp_dst_o
);
   localparam int unsigned ROB_SLOTS = 1 << TAG_W;

   if (NUM_ENT < 2) begin : g_bad_ent
      $error("rs_tag_pool: NUM_ENT must be at least 2");
   end
   if (NUM_ENT > ROB_SLOTS) begin : g_bad_tag
      $error("rs_tag_pool: more slots than reorder-buffer indices");
   end
   if (DATA_W < 1 || OP_W < 1) begin : g_bad_w
      $error("rs_tag_pool: widths must be positive");
   end

   logic [NUM_ENT-1:0] busy, req, sel, pick, alloc_vec, take_vec;
   logic               any_free;
   logic [NUM_ENT-1:0][OP_W-1:0]  e_op;
   logic [NUM_ENT-1:0][TAG_W-1:0] e_dst;
   logic [NUM_ENT-1:0][RS_NUM_SRC-1:0][DATA_W-1:0] e_src;
   logic [RS_NUM_SRC-1:0]              in_ok;
   logic [RS_NUM_SRC-1:0][TAG_W-1:0]   in_tag;
   logic [RS_NUM_SRC-1:0][DATA_W-1:0]  in_val;

   assign in_ok  = {iss_b_ok_i,  iss_a_ok_i};
   assign in_tag = {iss_b_tag_i, iss_a_tag_i};
   assign in_val = {iss_b_val_i, iss_a_val_i};

   rs_pick_free #(.NUM_ENT(NUM_ENT), .LOW_FIRST(LOW_FIRST)) i_pick (
      .free (~busy),
      .pick (pick),
      .any  (any_free)
   );

   assign iss_accept_o = iss_valid_i && iss_rob_room_i && any_free && !flush_i;
   assign alloc_vec    = pick & {NUM_ENT{iss_accept_o}};
   assign pool_full_o  = !any_free;

   rs_age #(.NUM_ENT(NUM_ENT)) i_age (
      .clk   (clk),
      .rst_n (rst_n),
      .alloc (alloc_vec),
      .req   (req),
      .sel   (sel)
   );

   assign dsp_valid_o = (|sel) && !flush_i;
   assign take_vec    = sel & {NUM_ENT{dsp_ready_i && !flush_i}};

   for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
      rs_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) i_ent (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush     (flush_i),
         .alloc     (alloc_vec[e]),
         .take      (take_vec[e]),
         .in_op     (iss_op_i),
         .in_dst    (iss_dst_i),
         .in_ok     (in_ok),
         .in_tag    (in_tag),
         .in_val    (in_val),
         .cdb_valid (cdb_valid_i),
         .cdb_tag   (cdb_tag_i),
         .cdb_val   (cdb_val_i),
         .busy      (busy[e]),
         .req       (req[e]),
         .op        (e_op[e]),
         .dst       (e_dst[e]),
         .src_val   (e_src[e])
      );
   end

   always_comb begin
      dsp_op_o  = '0;
      dsp_dst_o = '0;
      dsp_a_o   = '0;
      dsp_b_o   = '0;
      for (int i = 0; i < NUM_ENT; i++) begin
         if (sel[i]) begin
            dsp_op_o  = dsp_op_o  | e_op[i];
            dsp_dst_o = dsp_dst_o | e_dst[i];
            dsp_a_o   = dsp_a_o   | e_src[i][0];
            dsp_b_o   = dsp_b_o   | e_src[i][1];
         end
      end
   end

   AST_ONE_SLOT_PER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      iss_accept_o |-> ($countones(alloc_vec) == 1)); // R1
   AST_OFFER_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_valid_o |-> ($countones(sel & busy) == 1)); // R6
   AST_QUIET_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !dsp_valid_o); // R9
endmodule

// File: tb/test_rs_tag_pool.sv
`timescale 1ns/1ps
module test_rs_tag_pool;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush_i = 1'b0;
   logic        iss_valid_i = 1'b0, iss_rob_room_i = 1'b0;
   logic [3:0]  iss_op_i = '0;
   logic [2:0]  iss_dst_i = '0;
   logic        iss_a_ok_i = 1'b0, iss_b_ok_i = 1'b0;
   logic [15:0] iss_a_val_i = '0, iss_b_val_i = '0;
   logic [2:0]  iss_a_tag_i = '0, iss_b_tag_i = '0;
   logic        iss_accept_o, pool_full_o;
   logic        cdb_valid_i = 1'b0;
   logic [2:0]  cdb_tag_i = '0;
   logic [15:0] cdb_val_i = '0;
   logic        dsp_valid_o;
   logic        dsp_ready_i = 1'b0;
   logic [3:0]  dsp_op_o;
   logic [15:0] dsp_a_o, dsp_b_o;
   logic [2:0]  dsp_dst_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rs_tag_pool i_rs_tag_pool (.*);

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      iss_valid_i = 1'b0; iss_rob_room_i = 1'b1;
      cdb_valid_i = 1'b0; flush_i = 1'b0;
   endtask

   task automatic put(input logic [3:0] op, input logic [2:0] dst,
                      input logic aok, input logic [15:0] av, input logic [2:0] at,
                      input logic bok, input logic [15:0] bv, input logic [2:0] bt);
      iss_valid_i = 1'b1; iss_rob_room_i = 1'b1;
      iss_op_i = op; iss_dst_i = dst;
      iss_a_ok_i = aok; iss_a_val_i = av; iss_a_tag_i = at;
      iss_b_ok_i = bok; iss_b_val_i = bv; iss_b_tag_i = bt;
   endtask

   task automatic bcast(input logic [2:0] tag, input logic [15:0] v);
      cdb_valid_i = 1'b1; cdb_tag_i = tag; cdb_val_i = v;
   endtask

   task automatic t_reset();
      #1;
      chk("R1", "pool_full after reset", pool_full_o, 0);
      chk("R6", "dsp_valid after reset", dsp_valid_o, 0);
   endtask

   task automatic t_basic();
      tick(); put(4'h3, 3'd2, 1, 16'h1111, 3'd0, 1, 16'h2222, 3'd0);
      #1 chk("R1", "accept free pool", iss_accept_o, 1);
      tick(); idle();
      #1 chk("R6", "offer when both values", dsp_valid_o, 1);
      chk("R3", "op", dsp_op_o, 4'h3);
      chk("R2", "a value", dsp_a_o, 16'h1111);
      chk("R2", "b value", dsp_b_o, 16'h2222);
      chk("R3", "dst", dsp_dst_o, 3'd2);
      dsp_ready_i = 1'b1;
      tick(); dsp_ready_i = 1'b0;
      #1 chk("R6", "not offered again", dsp_valid_o, 0);
      bcast(3'd2, 16'h0);
      tick(); idle();
   endtask

   task automatic t_wait();
      tick(); put(4'h5, 3'd4, 0, 16'h0, 3'd5, 1, 16'h0b0b, 3'd0);
      tick(); idle();
      #1 chk("R2", "waiting source blocks offer", dsp_valid_o, 0);
      bcast(3'd6, 16'hdead);
      tick(); bcast(3'd5, 16'hbeef);
      #1 chk("R4", "other tag ignored", dsp_valid_o, 0);
      tick(); idle();
      #1 chk("R4", "offer after capture", dsp_valid_o, 1);
      chk("R4", "captured a", dsp_a_o, 16'hbeef);
      chk("R3", "b kept", dsp_b_o, 16'h0b0b);
      chk("R3", "dst", dsp_dst_o, 3'd4);
      dsp_ready_i = 1'b1;
      tick(); dsp_ready_i = 1'b0; bcast(3'd4, 16'h0);
      tick(); idle();
   endtask

   task automatic t_same_cycle();
      tick(); put(4'h7, 3'd1, 1, 16'h0001, 3'd0, 0, 16'h0, 3'd3);
      bcast(3'd3, 16'h3333);
      tick(); idle();
      #1 chk("R5", "offer after issue-cycle capture", dsp_valid_o, 1);
      chk("R5", "captured b", dsp_b_o, 16'h3333);
      dsp_ready_i = 1'b1;
      tick(); dsp_ready_i = 1'b0; bcast(3'd1, 16'h0);
      tick(); idle();
   endtask

   task automatic t_order();
      tick(); put(4'h1, 3'd5, 0, 16'h0, 3'd7, 1, 16'h00b1, 3'd0);
      tick(); put(4'h2, 3'd6, 1, 16'h00a2, 3'd0, 1, 16'h00b2, 3'd0);
      tick(); put(4'h3, 3'd0, 1, 16'h00a3, 3'd0, 1, 16'h00b3, 3'd0);
      tick(); idle();
      #1 chk("R7", "oldest ready first", dsp_dst_o, 3'd6);
      dsp_ready_i = 1'b1;
      tick(); dsp_ready_i = 1'b0;
      #1 chk("R7", "next oldest", dsp_dst_o, 3'd0);
      bcast(3'd6, 16'h6666);
      tick(); idle(); put(4'h4, 3'd3, 1, 16'h00a4, 3'd0, 1, 16'h00b4, 3'd0);
      #1 chk("R8", "freed slot reusable", iss_accept_o, 1);
      tick(); idle();
      #1 chk("R7", "older slot at higher position wins", dsp_dst_o, 3'd0);
      dsp_ready_i = 1'b1;
      tick();
      #1 chk("R7", "younger slot next", dsp_dst_o, 3'd3);
      tick(); dsp_ready_i = 1'b0;
      put(4'h5, 3'd7, 0, 16'h0, 3'd1, 1, 16'h00b5, 3'd0);
      tick(); idle();
      #1 chk("R1", "pool full", pool_full_o, 1);
      put(4'h6, 3'd2, 1, 16'h1, 3'd0, 1, 16'h2, 3'd0);
      #1 chk("R1", "no accept when full", iss_accept_o, 0);
      tick(); idle(); bcast(3'd0, 16'h0);
      tick(); idle();
      #1 chk("R8", "result broadcast frees slot", pool_full_o, 0);
      flush_i = 1'b1;
      tick(); idle();
   endtask

   task automatic t_rob_full();
      tick(); put(4'h9, 3'd5, 1, 16'h5, 3'd0, 1, 16'h6, 3'd0);
      iss_rob_room_i = 1'b0;
      #1 chk("R1", "no accept without rob room", iss_accept_o, 0);
      tick(); idle();
      #1 chk("R1", "refused request left pool empty", dsp_valid_o, 0);
   endtask

   task automatic t_flush();
      tick(); put(4'h6, 3'd2, 1, 16'h0c0c, 3'd0, 1, 16'h0d0d, 3'd0);
      tick(); put(4'h7, 3'd4, 0, 16'h0, 3'd5, 1, 16'h0e0e, 3'd0);
      tick(); idle();
      #1 chk("R6", "offer before flush", dsp_valid_o, 1);
      flush_i = 1'b1; put(4'h8, 3'd1, 1, 16'h1, 3'd0, 1, 16'h2, 3'd0);
      #1 chk("R9", "no accept in flush cycle", iss_accept_o, 0);
      chk("R9", "no offer in flush cycle", dsp_valid_o, 0);
      tick(); idle();
      #1 chk("R9", "no offer after flush", dsp_valid_o, 0);
      chk("R9", "pool empty after flush", pool_full_o, 0);
      bcast(3'd5, 16'h5555);
      tick(); idle();
      #1 chk("R9", "flushed slot stays dead", dsp_valid_o, 0);
      for (int n = 0; n < 4; n++) begin
         put(4'h1, 3'(n), 1, 16'h1, 3'd0, 1, 16'h1, 3'd0);
         #1 chk("R9", "full capacity after flush", iss_accept_o, 1);
         tick();
      end
      idle();
      #1 chk("R1", "four accepts fill pool", pool_full_o, 1);
      flush_i = 1'b1;
      tick(); idle();
      #1 chk("R9", "single-cycle flush of full pool", pool_full_o, 0);
   endtask

   initial begin
      idle();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_basic();
      t_wait();
      t_same_cycle();
      t_order();
      t_rob_full();
      t_flush();
      tick();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule